// File: doc/BRIEF.md
# Wake-Up Event and Power-Management Signalling Controller

This block watches for three wake conditions while the device sits in a reduced-power state. The conditions are a magic-packet hit, a wake-frame match and a change in link state. A qualified condition sets two sticky status bits. The first is the power-management event status bit in the power-management control/status word. The second is the wake interrupt bit in the general status word. While either bit stays set, the block drives an active-low interrupt output and an active-high wake output.

Software uses one write port and one read port. Through them it programs the power state and the event enable, and it clears the status bits by writing ones to them. An event is monitored only when the power state field is nonzero (D1, D2 or D3) and the enable bit is 1. Two option inputs can suppress the magic-packet source and the link-change source.

A three-state machine sets the output level.
- `IDLE`: the block is disarmed and nothing is pending.
- `ARMED`: the block is in low power with the enable set, and nothing is pending.
- `PENDING`: at least one status bit is set.

The transitions are:
- IDLE→ARMED when the block becomes armed.
- ARMED→IDLE when it is disarmed.
- IDLE or ARMED→PENDING on a qualified event.
- PENDING→ARMED or PENDING→IDLE once both status bits are clear. The choice depends on the arming condition.

Top module: `wake_pme_ctrl`

## Requirements
- R1: After reset, both register words read 0, `irq_n` is 1 and `wake_o` is 0.
- R2: A write with `wr_sel`=0 stores `wr_data[1:0]` as the power state and `wr_data[8]` as the event enable. Both read back at the same positions when `rd_sel`=0.
- R3: A qualified event sets both status bits at the next clock edge. The power-management status is read at `rd_sel`=0 bit 15, and the wake interrupt is read at `rd_sel`=1 bit 28. The frame event always qualifies. An event counts as qualified only when the power state is nonzero and the enable is 1.
- R4: `irq_n` is 0 and `wake_o` is 1 exactly while at least one status bit is set. Both return to idle in the cycle after the last status bit is cleared.
- R5: Events are ignored while the power state is 0 or the enable is 0.
- R6: `ev_magic` is ignored while `dis_magic`=1, and `ev_link` is ignored while `dis_link`=1.
- R7: Each status bit is cleared only by writing 1 to its own position. A write with `wr_sel`=0 and bit 15 set clears the power-management status. A write with `wr_sel`=1 and bit 28 set clears the wake interrupt. Writing 0 to a bit leaves it unchanged.
- R8: A qualified event in the same cycle as a clearing write leaves the bit set.
- R9: Qualification uses the power state and enable held before the current cycle's write. An event in the same cycle as the write that arms the block is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = power-management word, 1 = status word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 = power-management word, 1 = status word |
| rd_data | output | 32 | Read data, combinational |
| ev_magic | input | 1 | Magic-packet hit pulse |
| ev_frame | input | 1 | Wake-frame match pulse |
| ev_link | input | 1 | Link-state change pulse |
| dis_magic | input | 1 | Suppress the magic-packet event |
| dis_link | input | 1 | Suppress the link-change event |
| irq_n | output | 1 | Interrupt, active low |
| wake_o | output | 1 | Wake request, active high |

## Verification
The bench builds the block with its default 32-bit data word and the three event sources. With these values, every field position that software decodes can be read back through the read port. All three event gates, including the two with disable options, are exercised.

Random write traffic often lands in the same cycle as an event pulse. This brings the clear-versus-set race and the arm-in-same-cycle case within reach, alongside the directed cases.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int unsigned WK_DATA_W    = 32;
    localparam int unsigned WK_PS_W      = 2;
    localparam int unsigned WK_EN_BIT    = 8;
    localparam int unsigned WK_PMSTS_BIT = 15;
    localparam int unsigned WK_INT_BIT   = 28;
    localparam int unsigned WK_NUM_EV    = 3;

    // event vector order
    localparam int unsigned EV_MAGIC = 0;
    localparam int unsigned EV_FRAME = 1;
    localparam int unsigned EV_LINK  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2
    } wake_state_t;
endpackage

// File: rtl/wake_pm_regs.sv
module wake_pm_regs
    import wake_pkg::*;
#(
    parameter int unsigned DATA_W = WK_DATA_W,
    parameter int unsigned PS_W   = WK_PS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic              pmsts_q,
    input  logic              wkint_q,
    output logic [PS_W-1:0]   ps_q,
    output logic              en_q,
    output logic              armed,
    output logic              clr_pmsts,
    output logic              clr_wkint,
    output logic [DATA_W-1:0] rd_data
);
    logic wr_pm;
    logic wr_st;

    assign wr_pm = wr_en && !wr_sel;
    assign wr_st = wr_en &&  wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
            en_q <= 1'b0;
        end else if (wr_pm) begin
            ps_q <= wr_data[PS_W-1:0];
            en_q <= wr_data[WK_EN_BIT];
        end
    end

    assign armed     = en_q && (ps_q != '0);
    assign clr_pmsts = wr_pm && wr_data[WK_PMSTS_BIT];
    assign clr_wkint = wr_st && wr_data[WK_INT_BIT];

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[PS_W-1:0]    = ps_q;
            rd_data[WK_EN_BIT]    = en_q;
            rd_data[WK_PMSTS_BIT] = pmsts_q;
        end else begin
            rd_data[WK_INT_BIT]   = wkint_q;
        end
    end
endmodule

// File: rtl/wake_event_qual.sv
module wake_event_qual
    import wake_pkg::*;
#(
    parameter int unsigned NUM_EV = WK_NUM_EV
) (
    input  logic [NUM_EV-1:0] ev,
    input  logic [NUM_EV-1:0] dis,
    input  logic              armed,
    output logic              hit
);
    logic [NUM_EV-1:0] gated;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        assign gated[g] = ev[g] && !dis[g];
    end

    assign hit = armed && (|gated);
endmodule

// File: rtl/wake_sticky_bit.sv
module wake_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic hit,
    input  logic pmsts_q,
    input  logic wkint_q,
    input  logic clr_pmsts,
    input  logic clr_wkint,
    output logic irq_n,
    output logic wake_o
);
    wake_state_t state_q;
    wake_state_t state_d;
    logic        keep;

    assign keep = (pmsts_q && !clr_pmsts) || (wkint_q && !clr_wkint);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit)        state_d = ST_PENDING;
                else if (armed) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit)         state_d = ST_PENDING;
                else if (!armed) state_d = ST_IDLE;
            end
            ST_PENDING: begin
                if (!hit && !keep) state_d = armed ? ST_ARMED : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n  = 1'b1;
        wake_o = 1'b0;
        unique case (state_q)
            ST_PENDING: begin
                irq_n  = 1'b0;
                wake_o = 1'b1;
            end
            default: begin
                irq_n  = 1'b1;
                wake_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl
    import wake_pkg::*;
#(
    parameter int unsigned DATA_W = WK_DATA_W,
    parameter int unsigned PS_W   = WK_PS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_magic,
    input  logic              ev_frame,
    input  logic              ev_link,
    input  logic              dis_magic,
    input  logic              dis_link,
    output logic              irq_n,
    output logic              wake_o
);
    localparam int unsigned NUM_STS = 2;

    logic [PS_W-1:0]      ps_q;
    logic                 en_q;
    logic                 armed;
    logic                 hit;
    logic [NUM_STS-1:0]   sts_q;
    logic [NUM_STS-1:0]   sts_clr;
    logic [WK_NUM_EV-1:0] ev_vec;
    logic [WK_NUM_EV-1:0] dis_vec;

    always_comb begin
        ev_vec            = '0;
        dis_vec           = '0;
        ev_vec[EV_MAGIC]  = ev_magic;
        ev_vec[EV_FRAME]  = ev_frame;
        ev_vec[EV_LINK]   = ev_link;
        dis_vec[EV_MAGIC] = dis_magic;
        dis_vec[EV_LINK]  = dis_link;
    end

    wake_pm_regs #(.DATA_W(DATA_W), .PS_W(PS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .pmsts_q   (sts_q[0]),
        .wkint_q   (sts_q[1]),
        .ps_q      (ps_q),
        .en_q      (en_q),
        .armed     (armed),
        .clr_pmsts (sts_clr[0]),
        .clr_wkint (sts_clr[1]),
        .rd_data   (rd_data)
    );

    wake_event_qual #(.NUM_EV(WK_NUM_EV)) u_qual (
        .ev    (ev_vec),
        .dis   (dis_vec),
        .armed (armed),
        .hit   (hit)
    );

    for (genvar s = 0; s < NUM_STS; s++) begin : g_sts
        wake_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hit),
            .clr_i (sts_clr[s]),
            .q_o   (sts_q[s])
        );
    end

    wake_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .hit       (hit),
        .pmsts_q   (sts_q[0]),
        .wkint_q   (sts_q[1]),
        .clr_pmsts (sts_clr[0]),
        .clr_wkint (sts_clr[1]),
        .irq_n     (irq_n),
        .wake_o    (wake_o)
    );
endmodule

// File: rtl/wake_pme_ctrl_chk.sv
module wake_pme_ctrl_chk
    import wake_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_sel,
    input logic [WK_DATA_W-1:0] wr_data,
    input logic                 ev_magic,
    input logic                 ev_frame,
    input logic                 ev_link,
    input logic                 dis_magic,
    input logic                 dis_link,
    input logic                 irq_n,
    input logic                 wake_o,
    input logic [WK_PS_W-1:0]   ps_q,
    input logic                 en_q,
    input logic [1:0]           sts_q
);
    logic qual_ev;
    assign qual_ev = (ps_q != '0) && en_q &&
                     (ev_frame || (ev_magic && !dis_magic) || (ev_link && !dis_link));

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        qual_ev |=> (sts_q == 2'b11)); // R3

    AST_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o == (|sts_q)) && (irq_n == !wake_o)); // R4

    AST_DISARMED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (((ps_q == '0) || !en_q) && (sts_q == 2'b00)) |=> (sts_q == 2'b00)); // R5

    AST_MAGIC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_magic && dis_magic && !ev_frame && !ev_link && (sts_q == 2'b00)) |=> (sts_q == 2'b00)); // R6

    AST_PM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[WK_PMSTS_BIT] && !qual_ev) |=> !sts_q[0]); // R7
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ev_magic  (ev_magic),
    .ev_frame  (ev_frame),
    .ev_link   (ev_link),
    .dis_magic (dis_magic),
    .dis_link  (dis_link),
    .irq_n     (irq_n),
    .wake_o    (wake_o),
    .ps_q      (ps_q),
    .en_q      (en_q),
    .sts_q     (sts_q)
);

// File: tb/tb_wake_pme_ctrl.sv
`timescale 1ns/100ps
module tb_wake_pme_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        ev_magic = 1'b0, ev_frame = 1'b0, ev_link = 1'b0;
    logic        dis_magic = 1'b0, dis_link = 1'b0;
    logic        irq_n, wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [1:0] m_ps;
    logic       m_en, m_pm, m_wk;

    always #2 clk = ~clk;

    wake_pme_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ev_magic(ev_magic), .ev_frame(ev_frame),
        .ev_link(ev_link), .dis_magic(dis_magic), .dis_link(dis_link),
        .irq_n(irq_n), .wake_o(wake_o)
    );

    function automatic logic [31:0] exp_word0();
        logic [31:0] w = '0;
        w[1:0] = m_ps; w[8] = m_en; w[15] = m_pm;
        return w;
    endfunction

    function automatic logic [31:0] exp_word1();
        logic [31:0] w = '0;
        w[28] = m_wk;
        return w;
    endfunction

    function automatic logic exp_hit(logic em, logic ef, logic el, logic dm, logic dl);
        return (m_ps != 2'd0) && m_en && (ef || (em && !dm) || (el && !dl));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic verify(string tag);
        chk({tag, " wake_o"}, {31'd0, wake_o}, {31'd0, (m_pm | m_wk)});
        chk({tag, " irq_n"},  {31'd0, irq_n},  {31'd0, !(m_pm | m_wk)});
        rd_sel = 1'b0; #0.2;
        chk({tag, " word0"}, rd_data, exp_word0());
        rd_sel = 1'b1; #0.2;
        chk({tag, " word1"}, rd_data, exp_word1());
    endtask

    // one cycle: drive at negedge, update model at posedge, check after
    task automatic cyc(string tag, logic we, logic ws, logic [31:0] wd,
                       logic em, logic ef, logic el, logic dm, logic dl);
        logic h, cp, cw;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        ev_magic = em; ev_frame = ef; ev_link = el; dis_magic = dm; dis_link = dl;
        @(posedge clk);
        h  = exp_hit(em, ef, el, dm, dl);
        cp = we && !ws && wd[15];
        cw = we &&  ws && wd[28];
        m_pm = h ? 1'b1 : (cp ? 1'b0 : m_pm);
        m_wk = h ? 1'b1 : (cw ? 1'b0 : m_wk);
        if (we && !ws) begin m_ps = wd[1:0]; m_en = wd[8]; end
        #1;
        verify(tag);
    endtask

    function automatic logic [31:0] pmw(logic [1:0] ps, logic en, logic clr);
        logic [31:0] w = '0;
        w[1:0] = ps; w[8] = en; w[15] = clr;
        return w;
    endfunction

    localparam logic [31:0] WK_CLR = 32'h1000_0000;

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        void'($urandom(seed));
        m_ps = 0; m_en = 0; m_pm = 0; m_wk = 0;
        #10;
        verify("R1 reset");
        rst_n = 1'b1;
        cyc("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0);

        // R2 programming and readback
        cyc("R2 ps3 en", 1, 0, pmw(2'd3, 1, 0), 0, 0, 0, 0, 0);
        // R3/R4 frame event
        cyc("R3 frame", 0, 0, 0, 0, 1, 0, 0, 0);
        // R7 clear power-management status only; R4 outputs stay
        cyc("R7 clr pm", 1, 0, pmw(2'd3, 1, 1), 0, 0, 0, 0, 0);
        cyc("R7 wr0 no clr", 1, 1, 32'h0, 0, 0, 0, 0, 0);
        cyc("R4 clr wk release", 1, 1, WK_CLR, 0, 0, 0, 0, 0);
        // R6 masked sources
        cyc("R6 magic masked", 0, 0, 0, 1, 0, 0, 1, 0);
        cyc("R6 link masked", 0, 0, 0, 0, 0, 1, 0, 1);
        cyc("R6 magic live", 0, 0, 0, 1, 0, 0, 0, 1);
        cyc("R7 clr pm", 1, 0, pmw(2'd1, 1, 1), 0, 0, 0, 0, 0);
        cyc("R7 clr wk", 1, 1, WK_CLR, 0, 0, 0, 0, 0);
        cyc("R6 link live", 0, 0, 0, 0, 0, 1, 1, 0);
        // R8 event with clearing write
        cyc("R8 race pm", 1, 0, pmw(2'd1, 1, 1), 0, 1, 0, 0, 0);
        cyc("R8 race wk", 1, 1, WK_CLR, 0, 0, 1, 0, 0);
        cyc("R7 clr pm", 1, 0, pmw(2'd1, 1, 1), 0, 0, 0, 0, 0);
        cyc("R7 clr wk", 1, 1, WK_CLR, 0, 0, 0, 0, 0);
        // R5 disarmed
        cyc("R5 ps0", 1, 0, pmw(2'd0, 1, 0), 0, 0, 0, 0, 0);
        cyc("R5 ps0 ev", 0, 0, 0, 1, 1, 1, 0, 0);
        cyc("R5 en0", 1, 0, pmw(2'd2, 0, 0), 0, 0, 0, 0, 0);
        cyc("R5 en0 ev", 0, 0, 0, 1, 1, 1, 0, 0);
        // R9 arming write and event in the same cycle
        cyc("R9 arm+ev", 1, 0, pmw(2'd2, 1, 0), 0, 1, 0, 0, 0);
        cyc("R9 next ev", 0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R9 disarm+ev", 1, 0, pmw(2'd0, 0, 1), 0, 1, 0, 0, 0);
        cyc("R7 clr wk", 1, 1, WK_CLR, 0, 0, 0, 0, 0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic we, ws;
            logic [31:0] wd;
            we = ($urandom % 4) == 0;
            ws = $urandom % 2;
            wd = $urandom;
            cyc("R3 random", we, ws, wd,
                ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 8) == 0,
                $urandom % 2, $urandom % 2);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule